// File: doc/BRIEF.md
# Rectangle Fill Engine

This block paints a rectangle of pixels in a byte-wide frame memory. Software first loads the start corner, the size in pixels, the step directions, a 16-bit colour, a display configuration and a 4-bit logical operation, in any order. It then writes the opcode register, and the engine runs on its own. For each pixel it reads the byte that holds the pixel and combines the colour byte with the old contents through the logical operation. It then writes back only the bits that belong to that pixel. Addresses always follow a linear bitmap layout. X wraps inside the image line, and Y wraps modulo the memory size.

The two colour bytes are used in alternation across the bytes of a row. The pattern starts again at the beginning of each row. In tile mode only the low colour byte is taken from the colour register. The high byte keeps the value captured by the last fill started in bitmap mode. A busy output is high while the command runs. An end-of-command interrupt is raised when the last pixel is written and stays up until it is acknowledged.

The controller has four states. IDLE goes to READ when a start is accepted. READ always goes to MERGE, and MERGE always goes to WRITE. WRITE goes back to READ while pixels remain, and to IDLE after the last pixel.

Register map (`reg_addr`):
- 0: start X.
- 1: start Y.
- 2: pixel count per row (NX).
- 3: row count (NY).
- 4: directions. Bit 0 = X decrement, bit 1 = Y decrement.
- 5: colour, 16 bits.
- 6: mode. Bits 1:0 = depth (0 = 2 bpp, 1 = 4 bpp, 2 and 3 = 8 bpp). Bits 3:2 = width select (256 << sel pixels). Bit 4 = tile mode.
- 7: logical operation.
- 8: opcode (any data).

Top module: `rect_fill_engine`

## Requirements
- R1: A write to register 8 while idle starts a command using the parameter values present at that moment, whatever order they were written in. A write to register 8 while busy is ignored and causes no extra memory writes.
- R2: With X incrementing, the first byte of every row uses colour bits 7:0, the next byte bits 15:8, and so on alternately. In 8 bpp, colour 0x1234 with NX=4 writes 0x34, 0x12, 0x34, 0x12.
- R3: With X decrementing, the first byte of each row uses the high colour byte when the start byte column (X >> log2 pixels-per-byte) is odd, and the low byte when it is even. The bytes then alternate.
- R4: The byte address is ((Y << (8+sel)) | (X masked)) >> s, with s = 2, 1, 0 for 2, 4 and 8 bpp. In 4 bpp even X uses bits 7:4. In 2 bpp, X mod 4 = 0 uses bits 7:6, down to X mod 4 = 3 using bits 1:0.
- R5: In tile mode the fill uses the new low colour byte and the high byte captured by the most recent bitmap-mode start. That value is 0 after reset.
- R6: X is masked to the line width, so a row running past either edge continues at the other edge of the same line. Y wraps modulo the memory size.
- R7: Each written bit is lop[{colour_bit, old_bit}]. Bits outside the current pixel keep their old value.
- R8: busy is high from the accepted start until the last write. In the cycle busy falls, irq rises, and irq stays high until irq_ack.
- R9: Reset stops a running command at once, clears busy and irq, and no further memory writes follow.
- R10: Every pixel is a read (data returned on the next cycle) followed by a write to the same address two cycles after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 4 | register index |
| reg_wdata | input | 16 | register write data |
| mem_rd | output | 1 | memory read request |
| mem_wr | output | 1 | memory write request |
| mem_addr | output | AW | memory byte address |
| mem_wdata | output | 8 | memory write data |
| mem_rdata | input | 8 | read data, valid the cycle after mem_rd |
| busy | output | 1 | command in progress |
| irq | output | 1 | end-of-command interrupt |
| irq_ack | input | 1 | clears irq |

## Verification
The bench builds the engine with AW=12, a 4 KiB memory, and keeps the default 11-bit X and 12-bit Y coordinates. With 4 KiB of memory a 256-pixel line at 8 bpp leaves only 16 rows. A two-row fill stepping upward from row 0 therefore reaches the Y wrap. The widest line select still fits two full rows, so every width setting produces an address within reach.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_MERGE,
        ST_WRITE
    } rfe_state_t;

    typedef struct packed {
        logic [1:0] wsel;
        logic [1:0] bsel;
        logic       dix;
        logic       diy;
        logic [3:0] lop;
    } rfe_cfg_t;

    // log2 of pixels per byte for a depth code
    function automatic logic [1:0] depth_shift(input logic [1:0] bsel);
        unique case (bsel)
            2'd0:    return 2'd2;
            2'd1:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/rfe_regs.sv
module rfe_regs
    import rfe_pkg::*;
#(
    parameter int XW = 11,
    parameter int YW = 12,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [3:0]    addr,
    input  logic [15:0]   wdata,
    input  logic          busy,
    output logic [XW-1:0] dx,
    output logic [YW-1:0] dy,
    output logic [CW-1:0] nx,
    output logic [CW-1:0] ny,
    output logic [15:0]   colour,
    output logic          tile,
    output rfe_cfg_t      cfg,
    output logic          start
);

    localparam logic [3:0] A_DX  = 4'd0;
    localparam logic [3:0] A_DY  = 4'd1;
    localparam logic [3:0] A_NX  = 4'd2;
    localparam logic [3:0] A_NY  = 4'd3;
    localparam logic [3:0] A_DIR = 4'd4;
    localparam logic [3:0] A_COL = 4'd5;
    localparam logic [3:0] A_MOD = 4'd6;
    localparam logic [3:0] A_LOP = 4'd7;
    localparam logic [3:0] A_OPC = 4'd8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dx     <= '0;
            dy     <= '0;
            nx     <= '0;
            ny     <= '0;
            colour <= '0;
            tile   <= 1'b0;
            cfg    <= '0;
        end else if (we) begin
            unique case (addr)
                A_DX:  dx <= wdata[XW-1:0];
                A_DY:  dy <= wdata[YW-1:0];
                A_NX:  nx <= wdata[CW-1:0];
                A_NY:  ny <= wdata[CW-1:0];
                A_DIR: begin
                    cfg.dix <= wdata[0];
                    cfg.diy <= wdata[1];
                end
                A_COL: colour <= wdata;
                A_MOD: begin
                    cfg.bsel <= wdata[1:0];
                    cfg.wsel <= wdata[3:2];
                    tile     <= wdata[4];
                end
                A_LOP: cfg.lop <= wdata[3:0];
                default: ;
            endcase
        end
    end

    assign start = we && (addr == A_OPC) && !busy;

endmodule

// File: rtl/rfe_addr.sv
module rfe_addr #(
    parameter int XW = 11,
    parameter int YW = 12,
    parameter int AW = 19
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic [1:0]    wsel,
    input  logic [1:0]    shift,
    output logic [XW-1:0] wmask,
    output logic [AW-1:0] addr,
    output logic [7:0]    pmask
);

    localparam int LW = XW + YW;

    logic [3:0]    wlog;
    logic [LW-1:0] yl;
    logic [LW-1:0] xl;

    assign wlog  = 4'd8 + {2'b00, wsel};
    assign wmask = ~({XW{1'b1}} << wlog);
    assign yl    = LW'(y) << wlog;
    assign xl    = LW'(x & wmask);
    assign addr  = AW'((yl | xl) >> shift);

    always_comb begin
        unique case (shift)
            2'd1:    pmask = x[0] ? 8'h0F : 8'hF0;
            2'd2: begin
                unique case (x[1:0])
                    2'd0: pmask = 8'hC0;
                    2'd1: pmask = 8'h30;
                    2'd2: pmask = 8'h0C;
                    default: pmask = 8'h03;
                endcase
            end
            default: pmask = 8'hFF;
        endcase
    end

endmodule

// File: rtl/rfe_merge.sv
module rfe_merge (
    input  logic [7:0] old,
    input  logic [7:0] src,
    input  logic [7:0] pmask,
    input  logic [3:0] lop,
    output logic [7:0] result
);

    logic [7:0] op_out;

    for (genvar b = 0; b < 8; b++) begin : g_bit
        assign op_out[b] = lop[{src[b], old[b]}];
    end

    assign result = (old & ~pmask) | (op_out & pmask);

endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
    import rfe_pkg::*;
#(
    parameter int XW = 11,
    parameter int YW = 12,
    parameter int AW = 19,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          irq,
    input  logic          irq_ack
);

    rfe_state_t    state_q, state_d;

    logic [XW-1:0] dx_r;
    logic [YW-1:0] dy_r;
    logic [CW-1:0] nx_r, ny_r;
    logic [15:0]   col_r;
    logic          tile_r;
    rfe_cfg_t      cfg_r, cfg_q;
    logic          start;

    logic [XW-1:0] x_q, x0_q, x_nxt, wmask;
    logic [YW-1:0] y_q, y_nxt;
    logic [CW-1:0] ix_q, remx_q, remy_q, nx_q;
    logic [7:0]    col_lo_q, col_hi_q, wdata_q;
    logic [7:0]    src_byte, pmask, merged;
    logic [1:0]    shift;
    logic          sel_hi, last_px, irq_q;

    rfe_regs #(.XW(XW), .YW(YW), .CW(CW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .busy   (busy),
        .dx     (dx_r),
        .dy     (dy_r),
        .nx     (nx_r),
        .ny     (ny_r),
        .colour (col_r),
        .tile   (tile_r),
        .cfg    (cfg_r),
        .start  (start)
    );

    assign shift = depth_shift(cfg_q.bsel);

    rfe_addr #(.XW(XW), .YW(YW), .AW(AW)) u_addr (
        .x     (x_q),
        .y     (y_q),
        .wsel  (cfg_q.wsel),
        .shift (shift),
        .wmask (wmask),
        .addr  (mem_addr),
        .pmask (pmask)
    );

    // colour byte: alternates per byte of the row, phase set by start column on decrement
    assign sel_hi   = (cfg_q.dix & x0_q[shift]) ^ ix_q[shift];
    assign src_byte = sel_hi ? col_hi_q : col_lo_q;

    rfe_merge u_merge (
        .old    (mem_rdata),
        .src    (src_byte),
        .pmask  (pmask),
        .lop    (cfg_q.lop),
        .result (merged)
    );

    assign last_px = (remx_q == '0) && (remy_q == '0);
    assign x_nxt   = (cfg_q.dix ? (x_q - XW'(1)) : (x_q + XW'(1))) & wmask;
    assign y_nxt   = cfg_q.diy ? (y_q - YW'(1)) : (y_q + YW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_READ;
            ST_READ:  state_d = ST_MERGE;
            ST_MERGE: state_d = ST_WRITE;
            ST_WRITE: state_d = last_px ? ST_IDLE : ST_READ;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            x_q      <= '0;
            x0_q     <= '0;
            y_q      <= '0;
            ix_q     <= '0;
            remx_q   <= '0;
            remy_q   <= '0;
            nx_q     <= '0;
            col_lo_q <= '0;
            col_hi_q <= '0;
            wdata_q  <= '0;
            irq_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q    <= cfg_r;
                        x_q      <= dx_r;
                        x0_q     <= dx_r;
                        y_q      <= dy_r;
                        ix_q     <= '0;
                        remx_q   <= nx_r - CW'(1);
                        remy_q   <= ny_r - CW'(1);
                        nx_q     <= nx_r;
                        col_lo_q <= col_r[7:0];
                        if (!tile_r) col_hi_q <= col_r[15:8];
                    end
                end
                ST_MERGE: wdata_q <= merged;
                ST_WRITE: begin
                    if (remx_q == '0) begin
                        remx_q <= nx_q - CW'(1);
                        remy_q <= remy_q - CW'(1);
                        x_q    <= x0_q;
                        ix_q   <= '0;
                        y_q    <= y_nxt;
                    end else begin
                        remx_q <= remx_q - CW'(1);
                        x_q    <= x_nxt;
                        ix_q   <= ix_q + CW'(1);
                    end
                end
                default: ;
            endcase
            if (state_q == ST_WRITE && last_px) irq_q <= 1'b1;
            else if (irq_ack)                   irq_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        mem_rd    = (state_q == ST_READ);
        mem_wr    = (state_q == ST_WRITE);
        busy      = (state_q != ST_IDLE);
        mem_wdata = wdata_q;
        irq       = irq_q;
    end

endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
    parameter int AW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic          busy,
    input logic          irq,
    input logic          irq_ack
);

    // R10
    rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R8
    rd_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);

    // R10
    rd_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !mem_wr));

    // R10
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)));

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    // R8
    irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));

endmodule

bind rect_fill_engine rfe_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .busy     (busy),
    .irq      (irq),
    .irq_ack  (irq_ack)
);

// File: tb/rect_fill_engine_bench.sv
module rect_fill_engine_bench;

    localparam int AW   = 12;
    localparam int MEMN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic          mem_rd, mem_wr, busy, irq;
    logic          irq_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;

    always #4 clk = ~clk;

    rect_fill_engine #(.AW(AW)) u_rect_fill_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .irq       (irq),
        .irq_ack   (irq_ack)
    );

    typedef struct packed {
        logic [AW-1:0] a;
        logic [7:0]    d;
    } item_t;

    item_t       exp_q[$];
    logic [7:0]  mem    [MEMN];
    logic [7:0]  shadow [MEMN];
    logic [7:0]  hi_keep = 8'h00;
    int          checks = 0;
    int          fails  = 0;
    string       cur_req = "R1";
    logic        rd_d1 = 1'b0, rd_d2 = 1'b0;
    logic [AW-1:0] ad_d1 = '0, ad_d2 = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // memory model
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // monitor: pops the scoreboard on every write
    always @(negedge clk) begin
        item_t e;
        if (rst_n && mem_wr) begin
            // R10: read two cycles earlier at the same address
            check(rd_d2 && ad_d2 == mem_addr, "R10", "rmw spacing",
                  int'(ad_d2), int'(mem_addr));
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected write", int'(mem_addr), 0);
            end else begin
                e = exp_q.pop_front();
                check(mem_addr == e.a && mem_wdata == e.d, cur_req, "write addr/data",
                      int'({mem_addr, mem_wdata}), int'({e.a, e.d}));
            end
        end
        rd_d2 <= rd_d1;
        ad_d2 <= ad_d1;
        rd_d1 <= rst_n && mem_rd;
        ad_d1 <= mem_addr;
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    // expected writes from the requirements
    task automatic build(input int dx, input int dy, input int nx, input int ny,
                         input bit dix, input bit diy, input logic [15:0] col,
                         input bit tile, input int wsel, input int bsel,
                         input logic [3:0] lop);
        int wl, sh, wm, par, yy, xx, a, hi;
        logic [7:0] sc, mask, old, res, nv;
        wl = 8 + wsel;
        sh = (bsel == 0) ? 2 : (bsel == 1) ? 1 : 0;
        wm = (1 << wl) - 1;
        if (!tile) hi_keep = col[15:8];
        par = dix ? (((dx & wm) >> sh) & 1) : 0;
        for (int r = 0; r < ny; r++) begin
            yy = (diy ? dy - r : dy + r) & 12'hFFF;
            for (int i = 0; i < nx; i++) begin
                xx = (dix ? dx - i : dx + i) & wm;
                a  = (((yy << wl) | xx) >> sh) & (MEMN - 1);
                hi = par ^ ((i >> sh) & 1);
                sc = hi ? hi_keep : col[7:0];
                if (sh == 0)      mask = 8'hFF;
                else if (sh == 1) mask = (xx & 1) ? 8'h0F : 8'hF0;
                else              mask = 8'hC0 >> (2 * (xx & 3));
                old = shadow[a];
                for (int b = 0; b < 8; b++) res[b] = lop[{sc[b], old[b]}];
                nv = (old & ~mask) | (res & mask);
                shadow[a] = nv;
                exp_q.push_back('{a: AW'(a), d: nv});
            end
        end
    endtask

    task automatic run_fill(input string req, input int dx, input int dy,
                            input int nx, input int ny, input bit dix, input bit diy,
                            input logic [15:0] col, input bit tile, input int wsel,
                            input int bsel, input logic [3:0] lop, input bit rev,
                            input bit extra_start);
        cur_req = req;
        build(dx, dy, nx, ny, dix, diy, col, tile, wsel, bsel, lop);
        if (!rev) begin
            wr(4'd0, 16'(dx)); wr(4'd1, 16'(dy)); wr(4'd2, 16'(nx)); wr(4'd3, 16'(ny));
            wr(4'd4, {14'd0, diy, dix}); wr(4'd5, col);
            wr(4'd6, 16'({tile, 2'(wsel), 2'(bsel)})); wr(4'd7, {12'd0, lop});
        end else begin
            wr(4'd7, {12'd0, lop}); wr(4'd6, 16'({tile, 2'(wsel), 2'(bsel)}));
            wr(4'd5, col); wr(4'd4, {14'd0, diy, dix}); wr(4'd3, 16'(ny));
            wr(4'd2, 16'(nx)); wr(4'd1, 16'(dy)); wr(4'd0, 16'(dx));
        end
        wr(4'd8, 16'h0001);
        check(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
        if (extra_start) wr(4'd8, 16'h0001);
        while (busy) @(negedge clk);
        check(irq == 1'b1, "R8", "irq at end", int'(irq), 1);
        check(exp_q.size() == 0, req, "pending writes", exp_q.size(), 0);
        repeat (4) @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < MEMN; i++) begin
            mem[i]    = 8'h00;
            shadow[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R9: reset state
        check(busy == 0 && irq == 0 && mem_rd == 0 && mem_wr == 0, "R9", "reset state",
              int'({busy, irq, mem_rd, mem_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: 0x1234 at 8 bpp, 4 pixels
        run_fill("R2", 0, 0, 4, 1, 0, 0, 16'h1234, 0, 0, 2, 4'b1100, 0, 0);
        check(mem[0] == 8'h34 && mem[1] == 8'h12 && mem[2] == 8'h34 && mem[3] == 8'h12,
              "R2", "bytes 0..3", int'({mem[0], mem[1], mem[2], mem[3]}), 32'h34123412);

        // R2: alternation restarts on each row
        run_fill("R2", 16, 1, 3, 2, 0, 0, 16'h1234, 0, 0, 2, 4'b1100, 0, 0);
        check(mem[512 + 16] == 8'h34 && mem[512 + 17] == 8'h12, "R2", "second row start",
              int'({mem[528], mem[529]}), 16'h3412);

        // R3: decrement from odd column starts with high byte
        run_fill("R3", 5, 3, 3, 1, 1, 0, 16'h1234, 0, 0, 2, 4'b1100, 0, 0);
        check(mem[768 + 5] == 8'h12 && mem[768 + 4] == 8'h34 && mem[768 + 3] == 8'h12,
              "R3", "decrement bytes", int'({mem[773], mem[772], mem[771]}), 24'h123412);

        // R6: X wrap inside the line
        run_fill("R6", 254, 4, 4, 1, 0, 0, 16'h1234, 0, 0, 2, 4'b1100, 0, 0);
        check(mem[1024] == 8'h34 && mem[1025] == 8'h12 && mem[1280] == 8'h00, "R6",
              "x wrap", int'({mem[1024], mem[1025], mem[1280]}), 24'h341200);

        // R6: Y wrap, stepping up from row 0 lands on row 15
        run_fill("R6", 8, 0, 1, 2, 0, 1, 16'h1234, 0, 0, 2, 4'b1100, 0, 0);
        check(mem[15 * 256 + 8] == 8'h34, "R6", "y wrap", int'(mem[3848]), 8'h34);

        // R4: 4 bpp nibbles, colour bytes per byte column
        run_fill("R4", 0, 5, 4, 1, 0, 0, 16'h55AA, 0, 0, 1, 4'b1100, 0, 0);
        check(mem[640] == 8'hAA && mem[641] == 8'h55, "R4", "4bpp bytes",
              int'({mem[640], mem[641]}), 16'hAA55);

        // R4: 2 bpp, pixels 1..3 of one byte
        run_fill("R4", 1, 6, 3, 1, 0, 0, 16'h00E4, 0, 0, 0, 4'b1100, 0, 0);
        check(mem[384] == 8'h24, "R4", "2bpp byte", int'(mem[384]), 8'h24);

        // R4: widest line select
        run_fill("R4", 3, 1, 1, 1, 0, 0, 16'h00C7, 0, 3, 2, 4'b1100, 0, 0);
        check(mem[2051] == 8'hC7, "R4", "width 2048 address", int'(mem[2051]), 8'hC7);

        // R7: XOR over existing bytes
        run_fill("R7", 0, 0, 2, 1, 0, 0, 16'h0F0F, 0, 0, 2, 4'b0110, 0, 0);
        check(mem[0] == 8'h3B && mem[1] == 8'h1D, "R7", "xor result",
              int'({mem[0], mem[1]}), 16'h3B1D);

        // R5: tile mode keeps high byte 0x0F from the previous bitmap start
        run_fill("R5", 32, 7, 2, 1, 0, 0, 16'h5678, 1, 0, 2, 4'b1100, 0, 0);
        check(mem[7 * 256 + 32] == 8'h78 && mem[7 * 256 + 33] == 8'h0F, "R5",
              "tile colour bytes", int'({mem[1824], mem[1825]}), 16'h780F);

        // R1: reversed order, opcode rewritten while busy
        run_fill("R1", 40, 8, 5, 2, 0, 0, 16'hA1B2, 0, 0, 2, 4'b1100, 1, 1);
        repeat (20) @(negedge clk);
        check(busy == 0 && exp_q.size() == 0, "R1", "no second command",
              int'(busy), 0);

        // R8: irq held until ack
        cur_req = "R8";
        build(60, 9, 2, 1, 0, 0, 16'h0102, 0, 0, 2, 4'b1100);
        wr(4'd0, 16'd60); wr(4'd1, 16'd9); wr(4'd2, 16'd2); wr(4'd3, 16'd1);
        wr(4'd5, 16'h0102); wr(4'd8, 16'h0001);
        while (busy) @(negedge clk);
        repeat (6) @(negedge clk);
        check(irq == 1'b1, "R8", "irq held", int'(irq), 1);

        // R9: reset mid-command with irq still pending
        cur_req = "R9";
        build(0, 10, 200, 4, 0, 0, 16'h3333, 0, 0, 2, 4'b1100);
        wr(4'd0, 16'd0); wr(4'd1, 16'd10); wr(4'd2, 16'd200); wr(4'd3, 16'd4);
        wr(4'd5, 16'h3333); wr(4'd8, 16'h0001);
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        @(negedge clk);
        check(busy == 0 && irq == 0, "R9", "abort state", int'({busy, irq}), 0);
        hi_keep = 8'h00;
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        check(busy == 0 && mem_wr == 0, "R9", "quiet after abort", int'({busy, mem_wr}), 0);
        for (int i = 0; i < MEMN; i++) shadow[i] = mem[i];

        // R5: after reset the retained high byte is zero
        run_fill("R5", 100, 12, 2, 1, 0, 0, 16'hEE44, 1, 0, 2, 4'b1100, 0, 0);
        check(mem[12 * 256 + 101] == 8'h00 && mem[12 * 256 + 100] == 8'h44, "R5",
              "high byte after reset", int'({mem[3172], mem[3173]}), 16'h4400);

        finish_run();
    end

endmodule